// File: doc/BRIEF.md
# Dual-Clock FIFO with Latent Status Flags

This block is a first-in first-out buffer of 512 words of 9 bits. It has separate write and read clocks, and both of its enables are active low. Words enter on write-clock edges and leave through a registered output on read-clock edges. A two-bit status code reports the fill level: empty, almost empty, in between, or almost full. The read side owns the low flags and the write side owns the high flag. Each flag moves only on an edge of the clock that owns it.

Each pointer crosses into the other domain as gray code through a two-stage synchronizer. A state machine on each side classifies the fill level from its own pointer and the synchronized copy of the other pointer.

The read machine has three states: `RD_EMPTY`, `RD_LOW` and `RD_MID`.
- Every read edge reloads the read state, whatever the read enable is.
- In `RD_EMPTY` a read edge never removes a word, even with the enable asserted. The edge that leaves `RD_EMPTY` is therefore a flag-update cycle that delivers no data.
- In `RD_LOW` and `RD_MID` an asserted enable removes a word. On the same edge the state is set from the count that remains.
- Transitions: `RD_EMPTY`→`RD_LOW`/`RD_MID` on arrival of data; `RD_LOW`↔`RD_MID` across the 16-word level; `RD_LOW`/`RD_MID`→`RD_EMPTY` when the last word leaves.

The write machine has three states: `WR_OPEN`, `WR_HIGH` and `WR_FULL`.
- Every write edge reloads the write state in the same way.
- In `WR_FULL` writes are refused, so the edge that leaves `WR_FULL` is a write-side update cycle that stores nothing.
- Transitions: `WR_OPEN`↔`WR_HIGH` across 496 words; `WR_HIGH`→`WR_FULL` at 512 words; `WR_FULL`→`WR_HIGH` once a read is seen.

`WR_FULL` is internal and is not driven to a pin.

Top module: `lf_fifo`

## Requirements
- R1: After the asynchronous active-low reset, `status` is 00 (Empty) and `dout` is 0.
- R2: With both clocks running and no traffic, `status` settles to the code for the stored count N: 00 when N=0, 01 when 1≤N≤16, 11 when N≥496, and 10 for any other N. Bit 1 of `status` is the high pin and bit 0 is the low pin.
- R3: Words leave in the order they were written. A read edge with `ren_n` low, taken while the read state is not Empty, loads the next word into `dout` on that same edge.
- R4: The Empty code changes only on a read-clock edge. A write into an empty FIFO while the read clock is stopped leaves `status` at 00.
- R5: Leaving Empty takes a flag-update edge that delivers no word, even with `ren_n` low. With the two-stage synchronizer, the status leaves 00 on the third read edge after a write into an empty FIFO, and the word appears in `dout` on the fourth.
- R6: The almost-full code is cleared only by a write-clock edge. Reads with the write clock stopped leave `status` at 11. The third write edge after the reads clears it. A write edge with `wen_n` high stores nothing.
- R7: While the internal full state is set, writes are refused. The write edge that leaves the full state after a read also stores nothing. The next write edge with `wen_n` low is accepted.
- R8: A read attempted while the status is Empty changes neither `dout` nor the stored contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous reset, active low, for both domains |
| wen_n | input | 1 | Write enable, active low, sampled on `wclk` |
| din | input | 9 | Write data |
| ren_n | input | 1 | Read enable, active low, sampled on `rclk` |
| dout | output | 9 | Registered read data |
| status | output | 2 | Fill code: 00 Empty, 01 Almost Empty, 10 Intermediate, 11 Almost Full |

## Verification
The assertions assume that reset is applied before either clock does any work. They also assume each enable is stable around the rising edge of its own clock and that neither clock glitches. The bench meets these by driving every input just after a falling edge. It stops a clock only after a falling edge of the free-running source, and it gives single manual pulses only while that clock is parked low. Between steps of the fill and drain sweeps it idles long enough for the synchronized pointers to settle before it compares the status code.

// File: rtl/lf_fifo_pkg.sv
package lf_fifo_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY  = 2'b00,
        ST_AEMPTY = 2'b01,
        ST_MID    = 2'b10,
        ST_AFULL  = 2'b11
    } status_e;

    typedef enum logic [1:0] {
        RD_EMPTY = 2'd0,
        RD_LOW   = 2'd1,
        RD_MID   = 2'd2
    } rd_state_e;

    typedef enum logic [1:0] {
        WR_OPEN = 2'd0,
        WR_HIGH = 2'd1,
        WR_FULL = 2'd2
    } wr_state_e;

endpackage

// File: rtl/lf_dpram.sv
module lf_dpram #(
    parameter int W  = 9,
    parameter int AW = 9
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int ENTRIES = 1 << AW;

    logic [W-1:0] mem [ENTRIES];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/lf_sync.sv
module lf_sync #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/lf_rd_ctl.sv
module lf_rd_ctl
    import lf_fifo_pkg::*;
#(
    parameter int PW     = 10,
    parameter int AE_LVL = 16
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          ren_n,
    input  logic [PW-1:0] wgray_s,
    output logic          pop,
    output logic [PW-1:0] rptr,
    output logic [PW-1:0] rgray,
    output rd_state_e     state
);
    localparam logic [PW-1:0] AE_V = PW'(AE_LVL);

    logic [PW-1:0] wbin;
    logic [PW-1:0] occ;
    logic [PW-1:0] left;
    logic [PW-1:0] rptr_nxt;
    rd_state_e     nxt;

    for (genvar i = 0; i < PW; i++) begin : g_g2b
        assign wbin[i] = ^wgray_s[PW-1:i];
    end

    assign occ = wbin - rptr;

    always_comb begin
        pop = 1'b0;
        unique case (state)
            RD_EMPTY: pop = 1'b0;
            RD_LOW,
            RD_MID:   pop = !ren_n;
            default:  pop = 1'b0;
        endcase
        left     = occ - {{(PW-1){1'b0}}, pop};
        rptr_nxt = rptr + {{(PW-1){1'b0}}, pop};
        if (left == '0)        nxt = RD_EMPTY;
        else if (left <= AE_V) nxt = RD_LOW;
        else                   nxt = RD_MID;
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RD_EMPTY;
            rptr  <= '0;
            rgray <= '0;
        end else begin
            state <= nxt;
            rptr  <= rptr_nxt;
            rgray <= rptr_nxt ^ (rptr_nxt >> 1);
        end
    end
endmodule

// File: rtl/lf_wr_ctl.sv
module lf_wr_ctl
    import lf_fifo_pkg::*;
#(
    parameter int PW     = 10,
    parameter int DEPTH  = 512,
    parameter int AF_LVL = 16
) (
    input  logic          wclk,
    input  logic          rst_n,
    input  logic          wen_n,
    input  logic [PW-1:0] rgray_s,
    output logic          push,
    output logic [PW-1:0] wptr,
    output logic [PW-1:0] wgray,
    output wr_state_e     state
);
    localparam logic [PW-1:0] FULL_V = PW'(DEPTH);
    localparam logic [PW-1:0] HIGH_V = PW'(DEPTH - AF_LVL);

    logic [PW-1:0] rbin;
    logic [PW-1:0] occ;
    logic [PW-1:0] fill;
    logic [PW-1:0] wptr_nxt;
    wr_state_e     nxt;

    for (genvar i = 0; i < PW; i++) begin : g_g2b
        assign rbin[i] = ^rgray_s[PW-1:i];
    end

    assign occ = wptr - rbin;

    always_comb begin
        push = 1'b0;
        unique case (state)
            WR_FULL:  push = 1'b0;
            WR_OPEN,
            WR_HIGH:  push = !wen_n;
            default:  push = 1'b0;
        endcase
        fill     = occ + {{(PW-1){1'b0}}, push};
        wptr_nxt = wptr + {{(PW-1){1'b0}}, push};
        if (fill == FULL_V)     nxt = WR_FULL;
        else if (fill >= HIGH_V) nxt = WR_HIGH;
        else                    nxt = WR_OPEN;
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WR_OPEN;
            wptr  <= '0;
            wgray <= '0;
        end else begin
            state <= nxt;
            wptr  <= wptr_nxt;
            wgray <= wptr_nxt ^ (wptr_nxt >> 1);
        end
    end
endmodule

// File: rtl/lf_fifo.sv
module lf_fifo
    import lf_fifo_pkg::*;
#(
    parameter int W      = 9,
    parameter int DEPTH  = 512,
    parameter int AE_LVL = 16,
    parameter int AF_LVL = 16
) (
    input  logic         wclk,
    input  logic         rclk,
    input  logic         rst_n,
    input  logic         wen_n,
    input  logic [W-1:0] din,
    input  logic         ren_n,
    output logic [W-1:0] dout,
    output logic [1:0]   status
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic          push, pop;
    logic [PW-1:0] wptr, wgray, wgray_s;
    logic [PW-1:0] rptr, rgray, rgray_s;
    logic [W-1:0]  rdata;
    rd_state_e     rd_state;
    wr_state_e     wr_state;
    status_e       code;

    lf_wr_ctl #(.PW(PW), .DEPTH(DEPTH), .AF_LVL(AF_LVL)) u_wr (
        .wclk(wclk), .rst_n(rst_n), .wen_n(wen_n), .rgray_s(rgray_s),
        .push(push), .wptr(wptr), .wgray(wgray), .state(wr_state)
    );

    lf_rd_ctl #(.PW(PW), .AE_LVL(AE_LVL)) u_rd (
        .rclk(rclk), .rst_n(rst_n), .ren_n(ren_n), .wgray_s(wgray_s),
        .pop(pop), .rptr(rptr), .rgray(rgray), .state(rd_state)
    );

    lf_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s));
    lf_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

    lf_dpram #(.W(W), .AW(AW)) u_mem (
        .wclk(wclk), .we(push), .waddr(wptr[AW-1:0]), .wdata(din),
        .raddr(rptr[AW-1:0]), .rdata(rdata)
    );

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n)   dout <= '0;
        else if (pop) dout <= rdata;
    end

    always_comb begin
        unique case (rd_state)
            RD_EMPTY: code = ST_EMPTY;
            RD_LOW:   code = ST_AEMPTY;
            RD_MID:   code = (wr_state == WR_OPEN) ? ST_MID : ST_AFULL;
            default:  code = ST_EMPTY;
        endcase
    end

    assign status = code;
endmodule

// File: rtl/lf_fifo_chk.sv
module lf_fifo_chk
    import lf_fifo_pkg::*;
#(
    parameter int W     = 9,
    parameter int DEPTH = 512,
    parameter int PW    = 10
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst_n,
    input logic          wen_n,
    input logic          ren_n,
    input logic [W-1:0]  dout,
    input logic [PW-1:0] wptr,
    input logic [PW-1:0] rptr,
    input rd_state_e     rd_state,
    input wr_state_e     wr_state
);
    localparam logic [PW-1:0] FULL_V = PW'(DEPTH);

    // R5 R8
    no_read_when_empty_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (rd_state == RD_EMPTY) |=> ($stable(dout) && $stable(rptr)));

    // R3
    pop_advance_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (!ren_n && rd_state != RD_EMPTY) |=> (rptr == $past(rptr) + PW'(1)));

    // R7
    full_blocks_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_state == WR_FULL) |=> $stable(wptr));

    // R6
    idle_write_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        wen_n |=> $stable(wptr));

    // R7
    no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        ((wptr - rptr) <= FULL_V));
endmodule

bind lf_fifo lf_fifo_chk #(.W(W), .DEPTH(DEPTH), .PW(PW)) u_chk (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen_n(wen_n), .ren_n(ren_n),
    .dout(dout), .wptr(wptr), .rptr(rptr), .rd_state(rd_state), .wr_state(wr_state)
);

// File: tb/lf_fifo_tb.sv
`timescale 1ns/1ps
module lf_fifo_tb;
    logic       wclk_free = 1'b0, rclk_free = 1'b0;
    logic       wclk_man = 1'b0, rclk_man = 1'b0;
    logic       w_run = 1'b1, r_run = 1'b1;
    logic       wclk, rclk;
    logic       rst_n = 1'b0;
    logic       wen_n = 1'b1, ren_n = 1'b1;
    logic [8:0] din = '0;
    logic [8:0] dout;
    logic [1:0] status;

    int errors = 0;
    int checks = 0;

    assign wclk = w_run ? wclk_free : wclk_man;
    assign rclk = r_run ? rclk_free : rclk_man;

    initial forever #2.5 wclk_free = ~wclk_free;
    initial begin
        #1.3;
        forever #2.5 rclk_free = ~rclk_free;
    end

    lf_fifo u_dut (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen_n(wen_n), .din(din),
        .ren_n(ren_n), .dout(dout), .status(status)
    );

    function automatic logic [1:0] level_code(input int n);
        if (n == 0)        return 2'b00;
        else if (n <= 16)  return 2'b01;
        else if (n >= 496) return 2'b11;
        else               return 2'b10;
    endfunction

    function automatic logic [8:0] pat_a(input int i);
        return 9'((i * 37 + 5) & 511);
    endfunction

    function automatic logic [8:0] pat_b(input int i);
        return 9'((i * 11 + 200) & 511);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_word(input logic [8:0] d);
        @(negedge wclk); wen_n = 1'b0; din = d;
        @(negedge wclk); wen_n = 1'b1;
    endtask

    task automatic read_word();
        @(negedge rclk); ren_n = 1'b0;
        @(negedge rclk); ren_n = 1'b1;
    endtask

    task automatic settle();
        repeat (8) @(negedge wclk);
    endtask

    task automatic rpulse();
        #1 rclk_man = 1'b1; #2 rclk_man = 1'b0; #1;
    endtask

    task automatic wpulse();
        #1 wclk_man = 1'b1; #2 wclk_man = 1'b0; #1;
    endtask

    initial begin
        #900000;
        errors++;
        checks++;
        $display("FAIL watchdog expired, actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #20 rst_n = 1'b1;
        settle();
        // R1 reset state
        check("R1 status", status, 2'b00);
        check("R1 dout", dout, 0);

        // R8 read while empty
        read_word(); settle();
        check("R8 dout after empty read", dout, 0);
        check("R8 status after empty read", status, 2'b00);

        // R4 R5 write into empty with read clock parked
        @(negedge rclk_free); r_run = 1'b0;
        write_word(9'h155);
        repeat (20) @(negedge wclk);
        check("R4 status with read clock stopped", status, 2'b00);
        ren_n = 1'b0;
        rpulse(); check("R5 edge1 status", status, 2'b00);
        rpulse(); check("R5 edge2 status", status, 2'b00);
        check("R5 edge2 dout", dout, 0);
        rpulse(); check("R5 edge3 status", status, 2'b01);
        check("R5 edge3 no data", dout, 0);
        rpulse(); check("R5 edge4 dout", dout, 9'h155);
        check("R5 edge4 status", status, 2'b00);
        ren_n = 1'b1;
        @(negedge rclk_free); r_run = 1'b1;
        settle();

        // R2 fill sweep
        for (int i = 0; i < 512; i++) begin
            write_word(pat_a(i)); settle();
            check($sformatf("R2 fill n=%0d", i + 1), status, level_code(i + 1));
        end

        // R7 full blocking and latent write edge
        @(negedge wclk_free); w_run = 1'b0;
        read_word();
        check("R3 first out", dout, pat_a(0));
        repeat (8) @(negedge rclk);
        check("R6 status held with write clock stopped", status, 2'b11);
        wen_n = 1'b0;
        din = 9'h0A1; wpulse();
        din = 9'h0A2; wpulse();
        din = 9'h0A3; wpulse();
        check("R7 status after latent write edge", status, 2'b11);
        din = 9'h0A4; wpulse();
        wen_n = 1'b1;
        @(negedge wclk_free); w_run = 1'b1;
        settle();

        // R2 R3 R7 drain sweep
        for (int k = 0; k < 512; k++) begin
            read_word();
            check($sformatf("R3 R7 drain word %0d", k), dout,
                  (k < 511) ? pat_a(k + 1) : 9'h0A4);
            settle();
            check($sformatf("R2 drain n=%0d", 511 - k), status, level_code(511 - k));
        end

        // R8 underflow
        read_word(); settle();
        check("R8 dout after underflow read", dout, 9'h0A4);
        check("R8 status after underflow read", status, 2'b00);

        // R6 almost-full latent update with write enable high
        for (int i = 0; i < 497; i++) write_word(pat_b(i));
        settle();
        check("R2 fill 497", status, 2'b11);
        @(negedge wclk_free); w_run = 1'b0;
        read_word(); check("R3 pat_b 0", dout, pat_b(0));
        read_word(); check("R3 pat_b 1", dout, pat_b(1));
        repeat (8) @(negedge rclk);
        check("R6 status held after reads", status, 2'b11);
        wen_n = 1'b1; din = 9'h1FF;
        wpulse(); wpulse();
        check("R6 status after two write edges", status, 2'b11);
        wpulse();
        check("R6 status after third write edge", status, 2'b10);
        @(negedge wclk_free); w_run = 1'b1;
        settle();
        for (int k = 2; k < 497; k++) begin
            read_word();
            check($sformatf("R6 R3 drain word %0d", k), dout, pat_b(k));
        end
        settle();
        check("R6 empty after exact drain", status, 2'b00);
        read_word(); settle();
        check("R8 dout unchanged", dout, pat_b(496));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule